// File: doc/BRIEF.md
# Asymmetric Qualify/Release Level Debouncer

This block turns a noisy or slowly settling one-bit level into a clean level for synchronous logic. The raw input first passes a flop synchronizer. After that, a persistence counter decides when the clean output may change. The output goes high only once the synchronized input has stayed high, without a break, for a programmable number of timer ticks. It goes low only once the input has stayed low, without a break, for a second, independent number of ticks. Because the two counts are separate, a slow press can be qualified with a long window while the release is accepted sooner, or the other way round.

Timer ticks come from a free-running prescaler that divides the clock by a parameter. This lets tens of milliseconds be expressed with a modest count width. Whenever the output changes, the block raises a one-cycle strobe that marks the direction of the change. Typical use is switch, relay or slow-sensor conditioning in front of an interrupt or a state machine that must see each real transition exactly once.

Top module: `lvl_debounce_asym`

## Requirements
- R1: While reset is asserted and on the first cycle after it, clean_out, rise_evt and fall_evt are all 0.
- R2: From clean_out = 0, clean_out becomes 1 on the qual_cnt-th tick cycle of an unbroken run of cycles in which the synchronized input is 1.
- R3: From clean_out = 1, clean_out becomes 0 on the rel_cnt-th tick cycle of an unbroken run of cycles in which the synchronized input is 0. rel_cnt is independent of qual_cnt.
- R4: Any single cycle in which the synchronized input equals clean_out discards the progress made so far, so chatter shorter than the active window produces no output change and no event.
- R5: rise_evt is high for exactly the first cycle in which clean_out is 1 after being 0. fall_evt is high for exactly the first cycle in which clean_out is 0 after being 1. The two strobes are never high together, and each accepted transition gives exactly one strobe.
- R6: A tick cycle occurs on every TICK_DIV-th rising clock edge counted from reset release, the first at edge TICK_DIV (every edge when TICK_DIV = 1). Persistence advances only on tick cycles, and clean_out changes only on them.
- R7: A programmed count of 0 behaves as a count of 1.
- R8: raw_in passes SYNC_STAGES (default 2) flops before the persistence logic. With the defaults, a change of raw_in applied before clock edge 1 cannot alter clean_out before edge 3.
- R9: Counts use the full CNT_W-bit range (default 16) without wrap. A qualify count of 20000 ticks is honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Asynchronous noisy level |
| qual_cnt | input | CNT_W | Ticks of steady high needed to assert |
| rel_cnt | input | CNT_W | Ticks of steady low needed to deassert |
| clean_out | output | 1 | Debounced level |
| rise_evt | output | 1 | One-cycle strobe on an accepted rising change |
| fall_evt | output | 1 | One-cycle strobe on an accepted falling change |

## Verification
The hardest case to reach from the ports is a run that falls one tick short of the window and is then broken. Here the prescaler phase is not visible, so the exact tick on which the run ends is not known. The stimulus drives chatter bursts whose high (or low) phases last too few cycles to hold enough ticks at any prescaler phase, then holds the level long enough, and counts the strobes. A behavioural reference model uses a queue for the synchronizer delay and an integer phase counter. It predicts the clean level and both strobes on every clock, including the latency bounds across different prescaler phases and with a very large count.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

   // Direction strobes produced together with an accepted change
   typedef struct packed {
      logic rise;
      logic fall;
   } dbnc_evt_t;

   localparam dbnc_evt_t DBNC_EVT_NONE = '{rise: 1'b0, fall: 1'b0};

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/dbnc_tick.sv
module dbnc_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_en
);

   generate
      if (DIV == 1) begin : g_every
         assign tick_en = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              phase_q <= '0;
            else if (phase_q == LAST) phase_q <= '0;
            else                     phase_q <= phase_q + 1'b1;
         end

         assign tick_en = (phase_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/dbnc_persist.sv
module dbnc_persist
   import dbnc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             lvl_in,
   input  logic [CNT_W-1:0] qual_cnt,
   input  logic [CNT_W-1:0] rel_cnt,
   output logic             state_q,
   output dbnc_evt_t        evt_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] goal;
   logic [CNT_W:0]   run_nx;
   logic             differ;
   logic             hit;

   always_comb begin
      goal = state_q ? rel_cnt : qual_cnt;
      if (goal == '0) goal = ONE;
      differ = lvl_in ^ state_q;
      run_nx = {1'b0, run_q} + 1'b1;
      hit    = differ && tick_en && (run_nx >= {1'b0, goal});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         state_q <= 1'b0;
         evt_q   <= DBNC_EVT_NONE;
      end else begin
         evt_q <= DBNC_EVT_NONE;
         if (!differ) begin
            run_q <= '0;
         end else if (tick_en) begin
            if (hit) begin
               run_q      <= '0;
               state_q    <= lvl_in;
               evt_q.rise <= lvl_in;
               evt_q.fall <= ~lvl_in;
            end else begin
               run_q <= run_nx[CNT_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/lvl_debounce_asym.sv
module lvl_debounce_asym
   import dbnc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int TICK_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_in,
   input  logic [CNT_W-1:0] qual_cnt,
   input  logic [CNT_W-1:0] rel_cnt,
   output logic             clean_out,
   output logic             rise_evt,
   output logic             fall_evt
);

   generate
      if (CNT_W < 1)       begin : g_bad_w    $error("CNT_W must be at least 1");       end
      if (TICK_DIV < 1)    begin : g_bad_div  $error("TICK_DIV must be at least 1");    end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic      lvl_sync;
   logic      tick_en;
   dbnc_evt_t evt;

   dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .q_out (lvl_sync)
   );

   dbnc_tick #(.DIV(TICK_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en)
   );

   dbnc_persist #(.CNT_W(CNT_W)) u_persist (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .lvl_in   (lvl_sync),
      .qual_cnt (qual_cnt),
      .rel_cnt  (rel_cnt),
      .state_q  (clean_out),
      .evt_q    (evt)
   );

   assign rise_evt = evt.rise;
   assign fall_evt = evt.fall;

endmodule

// File: rtl/lvl_debounce_asym_chk.sv
module lvl_debounce_asym_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_en,
   input logic clean_out,
   input logic rise_evt,
   input logic fall_evt
);

   // R5: never both strobes
   a_r5_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise_evt, fall_evt}));

   // R5: a rising output change carries the rise strobe
   a_r5_rise_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clean_out) |-> rise_evt);

   // R5: a falling output change carries the fall strobe
   a_r5_fall_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clean_out) |-> fall_evt);

   // R5: rise strobe lasts a single cycle
   a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt |=> !rise_evt);

   // R5: fall strobe lasts a single cycle
   a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> !fall_evt);

   // R6: output moves only on the edge that closes a tick cycle
   a_r6_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (clean_out != $past(clean_out)) |-> $past(tick_en));

endmodule

bind lvl_debounce_asym lvl_debounce_asym_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .clean_out (clean_out),
   .rise_evt  (rise_evt),
   .fall_evt  (fall_evt)
);

// File: tb/test_lvl_debounce_asym.sv
module test_lvl_debounce_asym;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int DIV        = 4;
   localparam int WATCHDOG   = 190000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             raw_in = 1'b0;
   logic [CNT_W-1:0] qual_cnt = '0;
   logic [CNT_W-1:0] rel_cnt = '0;
   logic             clean_out, rise_evt, fall_evt;

   int n_checks = 0;
   int n_errors = 0;
   int rise_seen = 0;
   int fall_seen = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvl_debounce_asym #(.CNT_W(CNT_W), .TICK_DIV(DIV), .SYNC_STAGES(2)) i_lvl_debounce_asym (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_in    (raw_in),
      .qual_cnt  (qual_cnt),
      .rel_cnt   (rel_cnt),
      .clean_out (clean_out),
      .rise_evt  (rise_evt),
      .fall_evt  (fall_evt)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_range(input string req, input string what, input int act, input int lo, input int hi);
      n_checks++;
      if (act < lo || act > hi) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
      end
   endtask

   // Behavioural reference model, stepped on each rising edge
   bit sq[$];
   int m_phase = 0;
   int m_run = 0;
   bit m_clean = 0, m_rise = 0, m_fall = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         sq = '{0, 0};
         m_phase = 0; m_run = 0;
         m_clean = 0; m_rise = 0; m_fall = 0;
      end else begin
         bit s;
         bit tick;
         int goal;
         s = sq.pop_front();
         sq.push_back(raw_in);
         tick = (m_phase == DIV - 1);
         m_phase = (m_phase + 1) % DIV;
         goal = m_clean ? int'(rel_cnt) : int'(qual_cnt);
         if (goal == 0) goal = 1;
         m_rise = 0; m_fall = 0;
         if (s != m_clean) begin
            if (tick) begin
               m_run++;
               if (m_run >= goal) begin
                  m_clean = s;
                  m_rise = s;
                  m_fall = !s;
                  m_run = 0;
               end
            end
         end else begin
            m_run = 0;
         end
      end
   end

   // Cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk("R2", "clean_out vs model", int'(clean_out), int'(m_clean));
         chk("R5", "rise_evt vs model", int'(rise_evt), int'(m_rise));
         chk("R5", "fall_evt vs model", int'(fall_evt), int'(m_fall));
         if (rise_evt) rise_seen++;
         if (fall_evt) fall_seen++;
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Count edges after a negedge input change until clean_out reaches tgt
   task automatic latency(input logic tgt, input int limit, output int n);
      n = 0;
      while (clean_out !== tgt && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : stim
      int n;
      int r0, f0;
      // R1: reset state
      @(negedge clk);
      chk("R1", "clean_out in reset", int'(clean_out), 0);
      chk("R1", "rise_evt in reset", int'(rise_evt), 0);
      chk("R1", "fall_evt in reset", int'(fall_evt), 0);
      cycles(2);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "clean_out after reset", int'(clean_out), 0);

      // R2 / R6 / R8: qualify latency with qual 6
      qual_cnt = 6; rel_cnt = 3;
      raw_in = 1'b1;
      latency(1'b1, 200, n);
      chk_range("R2", "qualify latency", n, 3 + 5*DIV, 2 + 6*DIV);
      chk_range("R8", "no change before third edge", n, 3, 1000);

      // R3: release uses its own count
      cycles(5);
      raw_in = 1'b0;
      latency(1'b0, 200, n);
      chk_range("R3", "release latency", n, 3 + 2*DIV, 2 + 3*DIV);

      // R7: zero counts act as one
      cycles(3);
      qual_cnt = 0; rel_cnt = 0;
      raw_in = 1'b1;
      latency(1'b1, 200, n);
      chk_range("R7", "zero qualify latency", n, 3, 2 + DIV);
      cycles(3);
      raw_in = 1'b0;
      latency(1'b0, 200, n);
      chk_range("R7", "zero release latency", n, 3, 2 + DIV);

      // R6: count of two across shifting prescaler phases
      qual_cnt = 2; rel_cnt = 1;
      for (int t = 0; t < 4; t++) begin
         cycles(3 + t);
         raw_in = 1'b1;
         latency(1'b1, 200, n);
         chk_range("R6", "tick-spaced latency", n, 3 + DIV, 2 + 2*DIV);
         cycles(2);
         raw_in = 1'b0;
         latency(1'b0, 200, n);
         chk_range("R6", "single-tick release", n, 3, 2 + DIV);
      end

      // R4: high chatter shorter than the window gives nothing
      cycles(4);
      qual_cnt = 5; rel_cnt = 5;
      r0 = rise_seen;
      for (int b = 0; b < 8; b++) begin
         raw_in = 1'b1; cycles(8);
         raw_in = 1'b0; cycles(3);
      end
      cycles(4);
      chk("R4", "rise strobes during chatter", rise_seen - r0, 0);
      chk("R4", "clean_out after chatter", int'(clean_out), 0);
      raw_in = 1'b1; cycles(40);
      chk("R5", "one rise strobe for held high", rise_seen - r0, 1);
      chk("R2", "clean_out after held high", int'(clean_out), 1);

      // R4: low chatter while high gives nothing
      f0 = fall_seen;
      for (int b = 0; b < 8; b++) begin
         raw_in = 1'b0; cycles(8);
         raw_in = 1'b1; cycles(3);
      end
      cycles(4);
      chk("R4", "fall strobes during chatter", fall_seen - f0, 0);
      chk("R4", "clean_out after low chatter", int'(clean_out), 1);
      raw_in = 1'b0; cycles(40);
      chk("R5", "one fall strobe for held low", fall_seen - f0, 1);
      chk("R3", "clean_out after held low", int'(clean_out), 0);

      // R9: large count without wrap
      qual_cnt = 20000; rel_cnt = 1;
      cycles(2);
      raw_in = 1'b1;
      latency(1'b1, 90000, n);
      chk_range("R9", "large qualify latency", n, 3 + 19999*DIV, 2 + 20000*DIV);
      raw_in = 1'b0;
      latency(1'b0, 200, n);
      chk_range("R3", "release after large qualify", n, 3, 2 + DIV);

      cycles(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule